// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counter that advances on a clock-enable tick, normally the instruction-rate enable of the surrounding core. Each tick first passes a selectable prescaler (divide by 1, 4 or 16). The resulting increment events step the count register. When the count already equals the period register, the next increment event returns the count to zero rather than stepping it, and that event is a match. Every match is exported at once as a one-cycle strobe, before any postscaling, so a serial shifter can use it as a bit-clock source. Matches also feed a 4-bit postscaler, which raises a sticky interrupt flag on every (N+1)th match.

Software reaches three registers over a small single-cycle write / combinational read bus: the count, the period and a control byte. Writing either the count or the control byte resets the hidden prescale and postscale counters. The interrupt flag is held by a two-state machine. FLAG_CLEAR moves to FLAG_RAISED on a postscaler terminal event (transition SET). FLAG_RAISED moves back to FLAG_CLEAR when the flag-clear input is high and no terminal event occurs in that cycle (transition ACK). Every other case holds the state, so a set in the same cycle as a clear leaves the flag raised.

Top module: `period_match_timer`

## Requirements
- R1: After reset the count reads 00h, the period reads FFh, the control byte reads 00h, and irq_flag and match_strobe are 0. The prescale and postscale counters are also cleared.
- R2: Each increment event steps the count by one. If the count equals the period at that event, the count loads 00h, and match_strobe is high for exactly the following cycle.
- R3: Control bits 1:0 select the prescale ratio. 00 gives one increment event per tick, 01 one per 4 ticks, and 10 or 11 one per 16 ticks.
- R4: Control bits 6:3 hold a value N. irq_flag is set on the clock after the (N+1)th match counted from a cleared postscaler, so 0000 gives 1:1 and 1111 gives 1:16.
- R5: Bus address 0 is the count, 1 is the period, 2 is the control byte and 3 reads 00h. Control bit 7 always reads 0, even after a write of 1.
- R6: While control bit 2 (run) is 0, ticks have no effect and the count holds its value.
- R7: A write to address 0 or address 2 clears both the prescale and postscale counters. A write to address 2 leaves the count unchanged.
- R8: A count write in the same cycle as a tick loads the written value, and no increment occurs in that cycle. The written value is compared with the period at the next increment event.
- R9: irq_flag stays high until a cycle with flag_clr high. A set event in that same cycle keeps the flag high.
- R10: match_strobe reflects every match before the postscaler, one strobe cycle per match.
- R11: With a period of 00h, every increment event is a match and the count stays at 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-rate enable, one tick per high cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| flag_clr | input | 1 | Clears the interrupt flag |
| irq_flag | output | 1 | Sticky interrupt flag from the postscaler |
| match_strobe | output | 1 | One-cycle pulse per period match, before postscaling |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a software count write and a tick. The bench raises tick_en and writes the count in one cycle, then checks that the written value appears without an extra step. The second pair is a postscaler terminal event and a flag clear. The bench drives flag_clr high in the very cycle whose tick completes a match at period 00h and 1:1 postscale, and judges that irq_flag is high afterwards and falls only on a later, lone clear.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    localparam int ADDR_W = 2;
    localparam int CTRL_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        REG_COUNT  = 2'd0,
        REG_PERIOD = 2'd1,
        REG_CTRL   = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        FLAG_CLEAR  = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_state_e;

    typedef struct packed {
        logic       rsvd;
        logic [3:0] post_sel;
        logic       run;
        logic [1:0] pre_sel;
    } ctrl_t;

endpackage

// File: rtl/pmt_prescaler.sv
module pmt_prescaler #(
    parameter int PRE_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       run,
    input  logic       clr,
    input  logic [1:0] sel,
    output logic       inc
);

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] limit;

    always_comb begin
        unique case (sel)
            2'b00:   limit = '0;
            2'b01:   limit = PRE_W'(3);
            default: limit = PRE_W'(15);
        endcase
    end

    assign inc = tick_en && run && !clr && (pre_cnt == limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
        end else if (clr) begin
            pre_cnt <= '0;
        end else if (tick_en && run) begin
            if (pre_cnt == limit) pre_cnt <= '0;
            else                  pre_cnt <= pre_cnt + 1'b1;
        end
    end

    p_pre_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> pre_cnt <= limit);

    p_pre_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> pre_cnt == '0);

    p_pre_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !inc);

endmodule

// File: rtl/pmt_count_core.sv
module pmt_count_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             match_ev,
    output logic             match_q
);

    assign match_ev = inc && (cnt == period);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt_wr) begin
            cnt <= wdata;
        end else if (inc) begin
            if (cnt == period) cnt <= '0;
            else               cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= match_ev;
    end

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !cnt_wr && (cnt != period) |=> cnt == CNT_W'($past(cnt) + 1'b1));

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !cnt_wr && (cnt == period) |=> cnt == '0 && match_q);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !inc && !cnt_wr |=> $stable(cnt));

    p_wr_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt == $past(wdata));

    p_strobe_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !match_ev |=> !match_q);

endmodule

// File: rtl/pmt_postscaler.sv
module pmt_postscaler #(
    parameter int POST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              match_ev,
    input  logic [POST_W-1:0] sel,
    input  logic              flag_clr,
    output logic              flag
);

    import pmt_pkg::*;

    logic [POST_W-1:0] post_cnt;
    logic              set_ev;
    flag_state_e       state_q;
    flag_state_e       state_d;

    assign set_ev = match_ev && !clr && (post_cnt == sel);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            post_cnt <= '0;
        end else if (clr) begin
            post_cnt <= '0;
        end else if (match_ev) begin
            if (post_cnt == sel) post_cnt <= '0;
            else                 post_cnt <= post_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR:  if (set_ev)              state_d = FLAG_RAISED;
            FLAG_RAISED: if (flag_clr && !set_ev) state_d = FLAG_CLEAR;
            default:                              state_d = FLAG_CLEAR;
        endcase
    end

    always_comb begin
        flag = (state_q == FLAG_RAISED);
    end

    p_post_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> post_cnt <= sel);

    p_post_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> post_cnt == '0);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev |=> flag);

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !flag_clr |=> flag);

    p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr && !set_ev |=> !flag);

endmodule

// File: rtl/period_match_timer.sv
module period_match_timer #(
    parameter int CNT_W  = 8,
    parameter int POST_W = 4,
    parameter int PRE_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             flag_clr,
    output logic             irq_flag,
    output logic             match_strobe
);

    import pmt_pkg::*;

    localparam int PAD_W = CNT_W - CTRL_W;

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] cnt;
    logic             cnt_wr;
    logic             ctrl_wr;
    logic             per_wr;
    logic             scaler_clr;
    logic             inc;
    logic             match_ev;

    assign cnt_wr     = bus_wr && (reg_sel_e'(bus_addr) == REG_COUNT);
    assign per_wr     = bus_wr && (reg_sel_e'(bus_addr) == REG_PERIOD);
    assign ctrl_wr    = bus_wr && (reg_sel_e'(bus_addr) == REG_CTRL);
    assign scaler_clr = cnt_wr || ctrl_wr;

    always_ff @(posedge clk) begin
        if (!rst_n)      period_q <= '1;
        else if (per_wr) period_q <= bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q      <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            ctrl_q.rsvd <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_sel_e'(bus_addr))
            REG_COUNT:  bus_rdata = cnt;
            REG_PERIOD: bus_rdata = period_q;
            REG_CTRL:   bus_rdata = {{PAD_W{1'b0}}, ctrl_q};
            default:    bus_rdata = '0;
        endcase
    end

    pmt_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .run     (ctrl_q.run),
        .clr     (scaler_clr),
        .sel     (ctrl_q.pre_sel),
        .inc     (inc)
    );

    pmt_count_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (inc),
        .cnt_wr   (cnt_wr),
        .wdata    (bus_wdata),
        .period   (period_q),
        .cnt      (cnt),
        .match_ev (match_ev),
        .match_q  (match_strobe)
    );

    pmt_postscaler #(.POST_W(POST_W)) u_post (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (scaler_clr),
        .match_ev (match_ev),
        .sel      (ctrl_q.post_sel),
        .flag_clr (flag_clr),
        .flag     (irq_flag)
    );

    p_ctrl_keeps_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> $stable(cnt));

    p_rsvd_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.rsvd == 1'b0);

    p_zero_period_r11: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !cnt_wr && period_q == '0 && cnt == '0 |=> cnt == '0 && match_strobe);

endmodule

// File: tb/period_match_timer_tb_top.sv
module period_match_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       flag_clr = 1'b0;
    logic       irq_flag;
    logic       match_strobe;

    int n_checks = 0;
    int n_fails  = 0;
    int mcount   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    period_match_timer dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_en      (tick_en),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .flag_clr     (flag_clr),
        .irq_flag     (irq_flag),
        .match_strobe (match_strobe)
    );

    always @(negedge clk) if (match_strobe) mcount++;

    // prescale code, postscale N, period, tick count
    localparam logic [39:0] VEC [7] = '{
        {8'd0, 8'd0,  8'd5,   16'd14},
        {8'd1, 8'd1,  8'd3,   16'd40},
        {8'd2, 8'd0,  8'd2,   16'd64},
        {8'd3, 8'd3,  8'd1,   16'd96},
        {8'd0, 8'd15, 8'd0,   16'd16},
        {8'd0, 8'd15, 8'd0,   16'd15},
        {8'd0, 8'd2,  8'd255, 16'd300}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic run_ticks(input int n);
        if (n > 0) begin
            @(posedge clk); #1;
            tick_en = 1'b1;
            repeat (n) @(posedge clk);
            #1 tick_en = 1'b0;
        end
    endtask

    task automatic pulse_clr();
        @(posedge clk); #1;
        flag_clr = 1'b1;
        @(posedge clk); #1;
        flag_clr = 1'b0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        int v;
        int base;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); check("R1 count", v, 0);
        rd(2'd1, v); check("R1 period", v, 255);
        rd(2'd2, v); check("R1 ctrl", v, 0);
        check("R1 flag", int'(irq_flag), 0);
        check("R1 strobe", int'(match_strobe), 0);
        rd(2'd3, v); check("R5 addr3", v, 0);

        // R5 bit 7 of control reads 0
        wr(2'd2, 8'hFF);
        rd(2'd2, v); check("R5 ctrl bit7", v, 8'h7F);
        wr(2'd2, 8'h00);

        // R3 R4 R2 R10 R11 vector table
        for (int i = 0; i < 7; i++) begin
            int pre, post, per, k, div, t, exp_m;
            pre  = int'(VEC[i][39:32]);
            post = int'(VEC[i][31:24]);
            per  = int'(VEC[i][23:16]);
            k    = int'(VEC[i][15:0]);
            div  = (pre == 0) ? 1 : (pre == 1) ? 4 : 16;
            t    = k / div;
            exp_m = t / (per + 1);
            wr(2'd1, 8'(per));
            wr(2'd0, 8'd0);
            wr(2'd2, {1'b0, 4'(post), 1'b1, 2'(pre)});
            pulse_clr();
            base = mcount;
            run_ticks(k);
            repeat (3) @(negedge clk);
            rd(2'd0, v);
            check($sformatf("R2 R3 vec%0d count", i), v, t % (per + 1));
            check($sformatf("R10 R11 vec%0d matches", i), mcount - base, exp_m);
            check($sformatf("R4 vec%0d flag", i), int'(irq_flag), (exp_m >= post + 1) ? 1 : 0);
        end

        // R6 run bit 0 holds count
        wr(2'd1, 8'd20);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'd7);
        run_ticks(10);
        rd(2'd0, v); check("R6 hold", v, 7);

        // R7 control write keeps count
        wr(2'd2, 8'h04);
        rd(2'd0, v); check("R7 ctrl keeps count", v, 7);

        // R7 control write clears prescaler
        wr(2'd1, 8'd50);
        wr(2'd0, 8'd0);
        wr(2'd2, 8'h05);
        run_ticks(3);
        wr(2'd2, 8'h05);
        run_ticks(3);
        rd(2'd0, v); check("R7 prescaler cleared", v, 0);
        run_ticks(1);
        rd(2'd0, v); check("R3 div4 step", v, 1);

        // R7 count write clears postscaler
        wr(2'd1, 8'd0);
        wr(2'd2, 8'h0C);
        wr(2'd0, 8'd0);
        pulse_clr();
        run_ticks(1);
        wr(2'd0, 8'd0);
        run_ticks(1);
        @(negedge clk);
        check("R7 postscaler cleared", int'(irq_flag), 0);
        run_ticks(1);
        @(negedge clk);
        check("R4 1:2 flag", int'(irq_flag), 1);

        // R8 write beats tick in same cycle
        wr(2'd1, 8'd20);
        wr(2'd2, 8'h04);
        wr(2'd0, 8'd0);
        @(posedge clk); #1;
        tick_en = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'd5;
        @(posedge clk); #1;
        tick_en = 1'b0; bus_wr = 1'b0;
        rd(2'd0, v); check("R8 write priority", v, 5);
        run_ticks(1);
        rd(2'd0, v); check("R8 step after write", v, 6);

        // R8 written value compared on next tick
        wr(2'd1, 8'd10);
        wr(2'd0, 8'd10);
        base = mcount;
        run_ticks(1);
        repeat (2) @(negedge clk);
        rd(2'd0, v); check("R8 written equals period", v, 0);
        check("R2 match after write", mcount - base, 1);

        // R9 set and clear in the same cycle
        wr(2'd1, 8'd0);
        wr(2'd2, 8'h04);
        wr(2'd0, 8'd0);
        pulse_clr();
        @(negedge clk);
        check("R9 cleared", int'(irq_flag), 0);
        @(posedge clk); #1;
        tick_en = 1'b1; flag_clr = 1'b1;
        @(posedge clk); #1;
        tick_en = 1'b0; flag_clr = 1'b0;
        repeat (4) @(negedge clk);
        check("R9 set wins and sticks", int'(irq_flag), 1);
        pulse_clr();
        @(negedge clk);
        check("R9 clear", int'(irq_flag), 0);

        finish_up();
    end

endmodule